// File: doc/BRIEF.md
# UART Register Bank with Prioritized Interrupt Identification

This block is the processor-facing register set of a 16550-style serial port. It sits on a byte-wide bus with a 3-bit offset. It holds the baud divisor, interrupt enables, FIFO control, line control, modem control, line status and a scratch byte. Each bus access completes in one cycle, and read data is returned combinationally for the cycle in which `bus_sel` is high. Any side effects of an access take hold at the next rising edge.

The receive queue storage lives outside the block. The bank sees the queue's occupancy and read byte. It issues pop, push and flush requests, and it learns through `rxq_full_hit` when a push finds the queue full. In loopback mode, bytes written to the data register go into the receive queue. Otherwise the transmitter is treated as always ready, and the written byte is dropped. Modem status, including its delta bits, comes from a separate block. That block is told when the status register has been read so that it can clear its deltas.

The bank derives one interrupt reason, chosen by fixed priority. `irq` is high in every cycle in which a reason is pending. It therefore follows every register read or write, and every change in queue occupancy, with no added latency.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the divisor reads low byte 0x01 (reference 1843200 / baud 115200 / 16) and high byte 0x00. IER reads 0x00, IIR reads 0x01, and `irq` is low.
- R2: While LCR bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. The data register and IER are left untouched, and no queue push or pop is issued.
- R3: An IER write keeps only bits 3:0, so bits 7:4 read back as 0. The enable bits are: 0 receive, 1 transmit-empty, 2 line status, 3 modem status.
- R4: The transmit-empty pending flag is set by an IER write that takes bit 1 from 0 to 1. A write that leaves bit 1 at 1 does not set it again.
- R5: A data-register write (offset 0, LCR bit 7 clear) always sets transmit-empty pending. When MCR bit 4 (loopback) is set, the write also pushes the byte to the receive queue. When MCR bit 4 is clear, nothing is pushed.
- R6: A loopback push that meets a full queue sets the overrun bit, LSR bit 1. An LSR read reports the bit and then clears it.
- R7: An LSR read always has bits 6 and 5 set, and bit 0 set exactly when the queue count is non-zero. Writes to offsets 5 and 6 have no effect. An MSR read (offset 6) returns the external modem status and pulses `mdm_rd`.
- R8: IIR bits 3:0 give the highest-priority reason, in this order:
  - overrun with enable bit 2 gives 0x6;
  - queue non-empty with enable bit 0 gives 0xC;
  - transmit-empty pending with enable bit 1 gives 0x2;
  - any modem delta bit (status bits 3:0) with enable bit 3 gives 0x0;
  - if none of these applies, the code is 0x1.
- R9: An IIR read that reports 0x2 clears transmit-empty pending. An IIR read that reports a higher-priority reason leaves the flag set.
- R10: IIR bits 7:6 read as 11 while the FIFO enable bit (FCR bit 0) is set, and as 00 otherwise.
- R11: An FCR write pulses `rxq_flush` when it changes the enable bit, with `rxq_flush_full` equal to the new enable value. It also pulses `rxq_flush` when it sets both the enable bit and bit 1, with `rxq_flush_full` high. An FCR write with bit 0 clear clears the enable bit.
- R12: `irq` is high exactly when the IIR reason is not 0x1.
- R13: A data read (LCR bit 7 clear) returns the queue's read byte. It pulses `rxq_pop` only when the queue count is non-zero.
- R14: The scratch register (offset 7) stores a written byte and returns it. MCR (offset 4) keeps bits 4:0 and drives `mcr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| irq | output | 1 | Interrupt request |
| rxq_count | input | CNT_W | Receive queue occupancy |
| rxq_rdata | input | 8 | Byte at the head of the receive queue |
| rxq_pop | output | 1 | Remove the head byte |
| rxq_push | output | 1 | Push a loopback byte |
| rxq_wdata | output | 8 | Byte to push |
| rxq_full_hit | input | 1 | Queue full during this push |
| rxq_flush | output | 1 | Empty the queue |
| rxq_flush_full | output | 1 | With flush: 1 = full depth, 0 = depth 1 |
| mdm_status | input | 8 | Modem status; bits 3:0 are delta flags |
| mdm_rd | output | 1 | Modem status was read this cycle |
| mcr_out | output | 5 | Modem control bits |

## Verification
The case that needs care is an IIR read that meets the prioritizer while transmit-empty pending is set. The read's clearing side effect must follow the reason actually reported, not merely the presence of the pending flag.

The bench forces a loopback overflow while the queue is non-empty and transmit-empty is pending. It then reads IIR several times, one after another. Each read must show the next reason down: 0x6, then 0xC after the overrun is read out of LSR, then 0x2 once the queue drains. Only after the read that reports 0x2 may the flag clear, which the final 0x1 read and the low `irq` confirm.

// File: rtl/urb_pkg.sv
package urb_pkg;
   typedef enum logic [2:0] {
      OFS_DATA = 3'd0,
      OFS_IER  = 3'd1,
      OFS_IIR  = 3'd2,
      OFS_LCR  = 3'd3,
      OFS_MCR  = 3'd4,
      OFS_LSR  = 3'd5,
      OFS_MSR  = 3'd6,
      OFS_SCR  = 3'd7
   } ofs_e;

   localparam logic [3:0] RSN_NONE = 4'h1;
   localparam logic [3:0] RSN_LINE = 4'h6;
   localparam logic [3:0] RSN_RXTO = 4'hC;
   localparam logic [3:0] RSN_THRE = 4'h2;
   localparam logic [3:0] RSN_MDM  = 4'h0;

   localparam int EN_RX   = 0;
   localparam int EN_THRE = 1;
   localparam int EN_LINE = 2;
   localparam int EN_MDM  = 3;

   localparam int LCR_DIV_BIT = 7;
   localparam int MCR_LOOP_BIT = 4;
endpackage

// File: rtl/urb_prio.sv
module urb_prio
   import urb_pkg::*;
(
   input  logic [3:0] ien,
   input  logic       ovr,
   input  logic       rx_avail,
   input  logic       thre_pend,
   input  logic       mdm_delta,
   output logic [3:0] reason
);
   always_comb begin
      if (ovr && ien[EN_LINE])             reason = RSN_LINE;
      else if (rx_avail && ien[EN_RX])     reason = RSN_RXTO;
      else if (thre_pend && ien[EN_THRE])  reason = RSN_THRE;
      else if (mdm_delta && ien[EN_MDM])   reason = RSN_MDM;
      else                                 reason = RSN_NONE;
   end
endmodule

// File: rtl/urb_fcr.sv
module urb_fcr (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic       fifo_on,
   output logic       flush,
   output logic       flush_full
);
   logic [7:0] fcr_q;
   logic       en_chg;

   assign fifo_on    = fcr_q[0];
   assign en_chg     = wr_en && (wdata[0] != fcr_q[0]);
   assign flush      = en_chg || (wr_en && wdata[0] && wdata[1]);
   assign flush_full = wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fcr_q <= '0;
      else if (wr_en) begin
         if (!wdata[0])   fcr_q <= '0;
         else             fcr_q <= wdata & 8'hC9;
      end
   end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import urb_pkg::*;
#(
   parameter int CNT_W       = 5,
   parameter int REF_HZ      = 1843200,
   parameter int BAUD        = 115200,
   parameter bit HAS_SCRATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             irq,
   input  logic [CNT_W-1:0] rxq_count,
   input  logic [7:0]       rxq_rdata,
   output logic             rxq_pop,
   output logic             rxq_push,
   output logic [7:0]       rxq_wdata,
   input  logic             rxq_full_hit,
   output logic             rxq_flush,
   output logic             rxq_flush_full,
   input  logic [7:0]       mdm_status,
   output logic             mdm_rd,
   output logic [4:0]       mcr_out
);
   localparam int DIV_RST = REF_HZ / BAUD / 16;
   localparam logic [15:0] DIV16 = 16'(DIV_RST);

   if (CNT_W < 1 || CNT_W > 16) begin : g_cnt_bad
      $error("CNT_W out of range");
   end
   if (DIV_RST < 1 || DIV_RST > 65535) begin : g_div_bad
      $error("reset divisor out of range");
   end

   logic [7:0] dll_q, dlh_q, lcr_q;
   logic [3:0] ier_q;
   logic [4:0] mcr_q;
   logic       oe_q, thre_pend_q;
   logic [7:0] scr_rd;
   logic [3:0] reason;
   logic       fifo_on, dlab, rx_avail;
   logic       rd, wr, div_lo, div_hi;
   logic       wr_data, wr_ier, wr_fcr, rd_data, rd_iir, rd_lsr;

   assign dlab     = lcr_q[LCR_DIV_BIT];
   assign rx_avail = rxq_count != '0;
   assign rd       = bus_sel && !bus_wr;
   assign wr       = bus_sel && bus_wr;
   assign div_lo   = dlab && (bus_addr == OFS_DATA);
   assign div_hi   = dlab && (bus_addr == OFS_IER);
   assign wr_data  = wr && (bus_addr == OFS_DATA) && !dlab;
   assign wr_ier   = wr && (bus_addr == OFS_IER) && !dlab;
   assign wr_fcr   = wr && (bus_addr == OFS_IIR);
   assign rd_data  = rd && (bus_addr == OFS_DATA) && !dlab;
   assign rd_iir   = rd && (bus_addr == OFS_IIR);
   assign rd_lsr   = rd && (bus_addr == OFS_LSR);

   assign rxq_push  = wr_data && mcr_q[MCR_LOOP_BIT];
   assign rxq_wdata = bus_wdata;
   assign rxq_pop   = rd_data && rx_avail;
   assign mdm_rd    = rd && (bus_addr == OFS_MSR);
   assign mcr_out   = mcr_q;
   assign irq       = reason != RSN_NONE;

   urb_prio u_prio (
      .ien       (ier_q),
      .ovr       (oe_q),
      .rx_avail  (rx_avail),
      .thre_pend (thre_pend_q),
      .mdm_delta (mdm_status[3:0] != 4'h0),
      .reason    (reason)
   );

   urb_fcr u_fcr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_fcr),
      .wdata      (bus_wdata),
      .fifo_on    (fifo_on),
      .flush      (rxq_flush),
      .flush_full (rxq_flush_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dll_q <= DIV16[7:0];
         dlh_q <= DIV16[15:8];
         lcr_q <= '0;
         ier_q <= '0;
         mcr_q <= '0;
      end else if (wr) begin
         if (div_lo)                   dll_q <= bus_wdata;
         else if (div_hi)              dlh_q <= bus_wdata;
         else if (wr_ier)              ier_q <= bus_wdata[3:0];
         else if (bus_addr == OFS_LCR) lcr_q <= bus_wdata;
         else if (bus_addr == OFS_MCR) mcr_q <= bus_wdata[4:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q        <= 1'b0;
         thre_pend_q <= 1'b0;
      end else begin
         if (rxq_push && rxq_full_hit) oe_q <= 1'b1;
         else if (rd_lsr)              oe_q <= 1'b0;
         if (wr_data || (wr_ier && !ier_q[EN_THRE] && bus_wdata[EN_THRE]))
            thre_pend_q <= 1'b1;
         else if (rd_iir && reason == RSN_THRE)
            thre_pend_q <= 1'b0;
      end
   end

   if (HAS_SCRATCH) begin : g_scr
      logic [7:0] scr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               scr_q <= '0;
         else if (wr && bus_addr == OFS_SCR)       scr_q <= bus_wdata;
      end
      assign scr_rd = scr_q;
   end else begin : g_noscr
      assign scr_rd = 8'hFF;
   end

   always_comb begin
      bus_rdata = 8'hFF;
      if (div_lo)      bus_rdata = dll_q;
      else if (div_hi) bus_rdata = dlh_q;
      else begin
         case (bus_addr)
            OFS_DATA: bus_rdata = rxq_rdata;
            OFS_IER:  bus_rdata = {4'h0, ier_q};
            OFS_IIR:  bus_rdata = {{2{fifo_on}}, 2'b00, reason};
            OFS_LCR:  bus_rdata = lcr_q;
            OFS_MCR:  bus_rdata = {3'b000, mcr_q};
            OFS_LSR:  bus_rdata = {1'b0, 2'b11, 3'b000, oe_q, rx_avail};
            OFS_MSR:  bus_rdata = mdm_status;
            OFS_SCR:  bus_rdata = scr_rd;
            default:  bus_rdata = 8'hFF;
         endcase
      end
   end
endmodule

module urb_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [7:0]       bus_rdata,
   input logic             irq,
   input logic [CNT_W-1:0] rxq_count,
   input logic             rxq_push,
   input logic             rxq_pop,
   input logic             rxq_full_hit,
   input logic             rxq_flush,
   input logic             dlab,
   input logic             thre_pend,
   input logic             oe,
   input logic             fifo_on
);
   // R2
   dlab_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && dlab && bus_addr == 3'd0) |-> (!rxq_push && !rxq_pop));
   // R3
   ier_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !dlab && bus_addr == 3'd1) |-> bus_rdata[7:4] == 4'h0);
   // R5
   data_wr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !dlab && bus_addr == 3'd0) |=> thre_pend);
   // R6
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxq_push && rxq_full_hit) |=> oe);
   // R7
   lsr_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == 3'd5) |->
      (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == (rxq_count != '0)));
   // R9
   iir_thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == 3'd2 && bus_rdata[3:0] == 4'h2) |=> !thre_pend);
   // R10
   iir_fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == 3'd2) |-> (bus_rdata[7:6] == {2{fifo_on}}));
   // R11
   flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_flush |-> (bus_sel && bus_wr && bus_addr == 3'd2));
   // R12
   irq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == 3'd2 && bus_rdata[3:0] == 4'h1) |-> !irq);
endmodule

bind uart_regbank urb_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_rdata    (bus_rdata),
   .irq          (irq),
   .rxq_count    (rxq_count),
   .rxq_push     (rxq_push),
   .rxq_pop      (rxq_pop),
   .rxq_full_hit (rxq_full_hit),
   .rxq_flush    (rxq_flush),
   .dlab         (dlab),
   .thre_pend    (thre_pend_q),
   .oe           (oe_q),
   .fifo_on      (fifo_on)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
   localparam int CNT_W = 5;
   localparam int NV = 25;
   // {is_read, addr, wdata, expected}
   localparam logic [19:0] TBL [NV] = '{
      {1'b1,3'd2,8'h00,8'h01},   // R1 IIR none
      {1'b1,3'd1,8'h00,8'h00},   // R1 IER
      {1'b1,3'd5,8'h00,8'h60},   // R7 LSR idle
      {1'b0,3'd3,8'h80,8'h00},
      {1'b1,3'd0,8'h00,8'h01},   // R1 divisor low
      {1'b1,3'd1,8'h00,8'h00},   // R1 divisor high
      {1'b0,3'd0,8'h34,8'h00},
      {1'b0,3'd1,8'h12,8'h00},
      {1'b1,3'd0,8'h00,8'h34},   // R2
      {1'b1,3'd1,8'h00,8'h12},   // R2
      {1'b0,3'd3,8'h03,8'h00},
      {1'b1,3'd3,8'h00,8'h03},
      {1'b1,3'd1,8'h00,8'h00},   // R2 IER untouched
      {1'b0,3'd7,8'h5A,8'h00},
      {1'b1,3'd7,8'h00,8'h5A},   // R14 scratch
      {1'b0,3'd1,8'hF8,8'h00},
      {1'b1,3'd1,8'h00,8'h08},   // R3
      {1'b0,3'd4,8'hFF,8'h00},
      {1'b1,3'd4,8'h00,8'h1F},   // R14 MCR
      {1'b0,3'd4,8'h00,8'h00},
      {1'b0,3'd2,8'h01,8'h00},
      {1'b1,3'd2,8'h00,8'hC1},   // R10
      {1'b0,3'd2,8'h00,8'h00},
      {1'b0,3'd1,8'h00,8'h00},
      {1'b1,3'd2,8'h00,8'h01}    // R10 off again
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic irq, rxq_pop, rxq_push, rxq_flush, rxq_flush_full, mdm_rd;
   logic [CNT_W-1:0] rxq_count = '0;
   logic [7:0] rxq_rdata = '0, rxq_wdata;
   logic rxq_full_hit = 1'b0;
   logic [7:0] mdm_status = 8'hB0;
   logic [4:0] mcr_out;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0] got;
   logic got_push, got_pop, got_fl, got_ff, got_mr;
   logic [7:0] got_pw;

   always #4 clk = ~clk;

   uart_regbank #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .rxq_count(rxq_count), .rxq_rdata(rxq_rdata),
      .rxq_pop(rxq_pop), .rxq_push(rxq_push), .rxq_wdata(rxq_wdata),
      .rxq_full_hit(rxq_full_hit), .rxq_flush(rxq_flush),
      .rxq_flush_full(rxq_flush_full), .mdm_status(mdm_status),
      .mdm_rd(mdm_rd), .mcr_out(mcr_out));

   task automatic acc(input bit w, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
      #1;
      got = bus_rdata; got_push = rxq_push; got_pw = rxq_wdata;
      got_pop = rxq_pop; got_fl = rxq_flush; got_ff = rxq_flush_full;
      got_mr = mdm_rd;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
      end
   endtask

   task automatic rd_chk(input string r, input logic [2:0] a, input logic [7:0] exp);
      acc(1'b0, a, 8'h00);
      chk(r, got, exp);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 chk("R1 irq after reset", {7'h0, irq}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk);

      for (int i = 0; i < NV; i++) begin
         acc(!TBL[i][19], TBL[i][18:16], TBL[i][15:8]);
         if (TBL[i][19]) chk($sformatf("table step %0d", i), got, TBL[i][7:0]);
      end

      // R4 edge sets pending
      acc(1'b1, 3'd1, 8'h02);
      chk("R4 irq on enable edge", {7'h0, irq}, 8'h01);
      rd_chk("R9 IIR thre", 3'd2, 8'h02);
      chk("R12 irq low after clear", {7'h0, irq}, 8'h00);
      rd_chk("R9 IIR cleared", 3'd2, 8'h01);
      acc(1'b1, 3'd1, 8'h02);
      rd_chk("R4 no rearm", 3'd2, 8'h01);
      acc(1'b1, 3'd1, 8'h00);
      acc(1'b1, 3'd1, 8'h02);
      rd_chk("R4 rearm", 3'd2, 8'h02);

      // R5 loopback push and pending
      acc(1'b1, 3'd4, 8'h10);
      acc(1'b1, 3'd0, 8'hA5);
      chk("R5 push loopback", {7'h0, got_push}, 8'h01);
      chk("R5 push byte", got_pw, 8'hA5);
      rd_chk("R5 pending", 3'd2, 8'h02);
      acc(1'b1, 3'd4, 8'h00);
      acc(1'b1, 3'd0, 8'h11);
      chk("R5 no push", {7'h0, got_push}, 8'h00);
      rd_chk("R5 pending no loop", 3'd2, 8'h02);

      // R8 / R6 / R9 priority walk
      acc(1'b1, 3'd1, 8'h07);
      acc(1'b1, 3'd4, 8'h10);
      rxq_full_hit = 1'b1;
      acc(1'b1, 3'd0, 8'h77);
      rxq_full_hit = 1'b0;
      rxq_count = 5'd3;
      rd_chk("R8 line first", 3'd2, 8'h06);
      chk("R12 irq high", {7'h0, irq}, 8'h01);
      rd_chk("R6 overrun shown", 3'd5, 8'h63);
      rd_chk("R6 overrun cleared", 3'd5, 8'h61);
      rd_chk("R8 rx second", 3'd2, 8'h0C);
      rxq_count = 5'd0;
      rd_chk("R9 thre survived", 3'd2, 8'h02);
      rd_chk("R9 thre gone", 3'd2, 8'h01);
      chk("R12 irq low", {7'h0, irq}, 8'h00);
      acc(1'b1, 3'd4, 8'h00);

      // R8 modem
      mdm_status = 8'hB1;
      acc(1'b1, 3'd1, 8'h08);
      chk("R12 irq modem", {7'h0, irq}, 8'h01);
      rd_chk("R8 modem code", 3'd2, 8'h00);
      rd_chk("R7 msr read", 3'd6, 8'hB1);
      chk("R7 mdm_rd pulse", {7'h0, got_mr}, 8'h01);
      mdm_status = 8'hB0;
      #1 chk("R12 irq modem gone", {7'h0, irq}, 8'h00);
      acc(1'b1, 3'd1, 8'h00);

      // R13 data read
      rxq_count = 5'd2; rxq_rdata = 8'h9C;
      rd_chk("R13 data byte", 3'd0, 8'h9C);
      chk("R13 pop", {7'h0, got_pop}, 8'h01);
      rxq_count = 5'd0;
      acc(1'b0, 3'd0, 8'h00);
      chk("R13 no pop empty", {7'h0, got_pop}, 8'h00);

      // R7 ignored writes
      acc(1'b1, 3'd5, 8'hFF);
      acc(1'b1, 3'd6, 8'hFF);
      rd_chk("R7 lsr unchanged", 3'd5, 8'h60);
      rd_chk("R7 msr unchanged", 3'd6, 8'hB0);

      // R11 FCR
      acc(1'b1, 3'd2, 8'h01);
      chk("R11 flush on enable", {6'h0, got_fl, got_ff}, 8'h03);
      acc(1'b1, 3'd2, 8'h03);
      chk("R11 flush rx reset", {6'h0, got_fl, got_ff}, 8'h03);
      acc(1'b1, 3'd2, 8'hC9);
      chk("R11 no flush", {7'h0, got_fl}, 8'h00);
      rd_chk("R11 enabled", 3'd2, 8'hC1);
      acc(1'b1, 3'd2, 8'h00);
      chk("R11 flush on disable", {6'h0, got_fl, got_ff}, 8'h02);
      rd_chk("R11 cleared", 3'd2, 8'h01);
      acc(1'b1, 3'd2, 8'h00);
      chk("R11 no flush idle", {7'h0, got_fl}, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule